// File: doc/BRIEF.md
# Gate-Level Opcode ALU

This block is a purely combinational 32-bit arithmetic logic unit. It takes two operands and a 3-bit operation code. It returns a 32-bit result and a flag that is high whenever that result is all zeros. It performs bitwise AND, bitwise OR, addition, subtraction, signed set-on-less-than and an equality comparison for branches. For the comparison, the caller reads the flag as "branch taken".

The whole datapath is built from gate primitives. A ripple-carry adder is made of full-adder cells. The AND and OR arrays are per-bit gates. Every multiplexer is a 2-to-1 cell made of AND, OR and NOT gates.

The operation code is split in two parts. The top bit is a negate control: it picks the inverted B through a 2-to-1 mux and sets the adder carry-in, so subtract, less-than and equal all share the one adder. The low two bits steer a 4-to-1 result mux, which is built by cascading the same 2-to-1 cells.

Top module: `gate_alu`

## Requirements
- R1: Opcode 3'b000 gives result = A & B, bit by bit.
- R2: Opcode 3'b001 gives result = A | B, bit by bit.
- R3: Opcode 3'b010 gives result = (A + B) mod 2^32. Any carry out of bit 31 is dropped.
- R4: Opcode 3'b110 gives result = (A - B) mod 2^32 in two's complement.
- R5: Opcode 3'b111 gives result = 32'd1 when A < B as signed 32-bit numbers, otherwise 32'd0. This holds also when A - B overflows.
- R6: Opcode 3'b100 gives result = (A - B) mod 2^32, so the zero flag is high exactly when A equals B.
- R7: For every opcode, the zero flag is 1 exactly when all 32 result bits are 0.
- R8: The unused opcodes 3'b011 and 3'b101 give a result of 32'd0, so the zero flag is 1.
- R9: No clock or state: both outputs depend only on the current A, B and opcode, and settle within 2 ns of an input change in the bench's timing model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand A |
| b_i | input | 32 | Second operand B |
| op_i | input | 3 | Operation code; bit 2 negates B and sets carry-in |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Result selection and zero detection act in the same evaluation. The case that matters is when the arithmetic path itself produces zero: equal operands under the branch-equal code, a wrap-around sum such as 0xFFFFFFFF + 1, and the unused codes. The bench drives each of these directly and checks both outputs against its own signed and modular model. Random operands across all eight codes then add coincidental zero and overflow cases. Near-equal pairs are included so that a single differing bit must lower the flag. Less-than is judged at the signed-overflow edges, such as the most negative value against positive numbers, where the sign bit of the difference alone gives the wrong answer.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int ALU_W = 32;
  localparam int OP_W  = 3;

  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD = 3'b010;
  localparam logic [OP_W-1:0] OP_UD3 = 3'b011;
  localparam logic [OP_W-1:0] OP_BEQ = 3'b100;
  localparam logic [OP_W-1:0] OP_UD5 = 3'b101;
  localparam logic [OP_W-1:0] OP_SUB = 3'b110;
  localparam logic [OP_W-1:0] OP_SLT = 3'b111;

  // bit of the opcode that negates B
  localparam int NEG_BIT = 2;
endpackage

// File: rtl/alu_mux2.sv
// W-bit 2-to-1 mux from AND/OR/NOT gates: y = sel ? d1 : d0
module alu_mux2 #(
  parameter int W = 32
) (
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  input  logic         sel_i,
  output logic [W-1:0] y_o
);
  logic sel_n;
  not g_inv (sel_n, sel_i);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic t0, t1;
    and g_a0 (t0, d0_i[i], sel_n);
    and g_a1 (t1, d1_i[i], sel_i);
    or  g_o  (y_o[i], t0, t1);
  end
endmodule

// File: rtl/alu_ripple_add.sv
// Ripple-carry adder; exposes carry into and out of the MSB for overflow
module alu_ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_msb_out_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p, g, t;
    xor g_p (p, a_i[i], b_i[i]);
    xor g_s (sum_o[i], p, c[i]);
    and g_g (g, a_i[i], b_i[i]);
    and g_t (t, p, c[i]);
    or  g_c (c[i+1], g, t);
  end

  assign c_msb_in_o  = c[W-1];
  assign c_msb_out_o = c[W];
endmodule

// File: rtl/alu_zero_detect.sv
// OR chain followed by an inverter
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  output logic         zero_o
);
  logic [W-1:0] acc;
  assign acc[0] = d_i[0];

  for (genvar i = 1; i < W; i++) begin : g_or
    or g_o (acc[i], acc[i-1], d_i[i]);
  end

  not g_n (zero_o, acc[W-1]);
endmodule

// File: rtl/gate_alu.sv
module gate_alu
  import alu_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o
);
  logic           neg;
  logic [W-1:0]   b_inv, b_eff;
  logic [W-1:0]   and_r, or_r, sum_r, slt_r;
  logic           c_in_msb, c_out_msb, ovf, lt;
  logic [W-1:0]   lane0, lane1, lane2, lane3, m_lo, m_hi;

  assign neg = op_i[NEG_BIT];

  // bitwise arrays
  for (genvar i = 0; i < W; i++) begin : g_bw
    not g_nb (b_inv[i], b_i[i]);
    and g_an (and_r[i], a_i[i], b_i[i]);
    or  g_or (or_r[i],  a_i[i], b_i[i]);
  end

  // B-negate mux; carry-in follows the same bit
  alu_mux2 #(.W(W)) u_bneg (
    .d0_i(b_i), .d1_i(b_inv), .sel_i(neg), .y_o(b_eff)
  );

  alu_ripple_add #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_eff), .cin_i(neg), .sum_o(sum_r),
    .c_msb_in_o(c_in_msb), .c_msb_out_o(c_out_msb)
  );

  // signed less-than: sign of difference corrected by overflow
  xor g_ovf (ovf, c_in_msb, c_out_msb);
  xor g_lt  (lt, sum_r[W-1], ovf);
  assign slt_r = {{(W-1){1'b0}}, lt};

  // per-lane pre-select by negate bit
  alu_mux2 #(.W(W)) u_l0 (.d0_i(and_r), .d1_i(sum_r), .sel_i(neg), .y_o(lane0));
  alu_mux2 #(.W(W)) u_l1 (.d0_i(or_r),  .d1_i('0),    .sel_i(neg), .y_o(lane1));
  assign lane2 = sum_r;
  alu_mux2 #(.W(W)) u_l3 (.d0_i('0),    .d1_i(slt_r), .sel_i(neg), .y_o(lane3));

  // 4-to-1 from cascaded 2-to-1 cells on op_i[1:0]
  alu_mux2 #(.W(W)) u_m0 (.d0_i(lane0), .d1_i(lane1), .sel_i(op_i[0]), .y_o(m_lo));
  alu_mux2 #(.W(W)) u_m1 (.d0_i(lane2), .d1_i(lane3), .sel_i(op_i[0]), .y_o(m_hi));
  alu_mux2 #(.W(W)) u_m2 (.d0_i(m_lo),  .d1_i(m_hi),  .sel_i(op_i[1]), .y_o(result_o));

  alu_zero_detect #(.W(W)) u_zd (.d_i(result_o), .zero_o(zero_o));
endmodule

// File: rtl/gate_alu_chk.sv
module gate_alu_chk
  import alu_pkg::*;
#(
  parameter int W = ALU_W
) (
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    result_o,
  input logic            zero_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, result_o, zero_o})) begin
      a_r7_zero_flag: assert (zero_o == (result_o == '0));
      if (op_i == OP_AND) begin
        a_r1_and_subset: assert (((result_o & ~a_i) | (result_o & ~b_i)) == '0);
      end
      if (op_i == OP_OR) begin
        a_r2_or_cover: assert ((result_o & a_i) == a_i && (result_o & b_i) == b_i);
      end
      if (op_i == OP_ADD) begin
        a_r3_add_lsb: assert (result_o[0] == (a_i[0] ^ b_i[0]));
      end
      if (op_i == OP_SUB) begin
        a_r4_sub_inverse: assert (result_o + b_i == a_i);
      end
      if (op_i == OP_SLT) begin
        a_r5_slt_binary: assert (result_o[W-1:1] == '0);
      end
      if (op_i == OP_BEQ) begin
        a_r6_beq_eq: assert (zero_o == (a_i == b_i));
      end
      if (op_i == OP_UD3 || op_i == OP_UD5) begin
        a_r8_unused_zero: assert (result_o == '0);
      end
    end
  end
endmodule

bind gate_alu gate_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_gate_alu.sv
`timescale 1ns/1ps
module sim_gate_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         zero;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  gate_alu u0 (.a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zero));

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [2:0] o);
    case (o)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return x + y;
      3'b110:  return x - y;
      3'b100:  return x - y;
      3'b111:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      3'b100: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o);
    logic [W-1:0] exp_r;
    @(negedge clk);
    a = x; b = y; op = o;
    #2;  // R9: settled without any clock edge
    exp_r = model(x, y, o);
    n_run++;
    if (res !== exp_r) begin
      n_fail++;
      $display("FAIL %s/R9 op=%b a=%h b=%h result got %h exp %h", req_of(o), o, x, y, res, exp_r);
    end
    n_run++;
    if (zero !== (exp_r == '0)) begin
      n_fail++;
      $display("FAIL R7 op=%b a=%h b=%h zero got %b exp %b", o, x, y, zero, exp_r == '0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'h5eed_1234));
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state with all-zero inputs: result 0, zero high (R1, R7)
    @(negedge clk);
    n_run++;
    if (res !== '0 || zero !== 1'b1) begin
      n_fail++;
      $display("FAIL R1/R7 reset result got %h/%b exp 0/1", res, zero);
    end
    // directed corners
    apply(32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b000); // R1
    apply(32'hF0F0_0000, 32'h0F0F_0001, 3'b001); // R2
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // R3 wrap to zero
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010); // R3
    apply(32'h0000_0000, 32'h0000_0001, 3'b110); // R4 borrow
    apply(32'h8000_0000, 32'h0000_0001, 3'b111); // R5 overflow, true
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111); // R5 overflow, false
    apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111); // R5 -1 < 0
    apply(32'h1234_5678, 32'h1234_5678, 3'b111); // R5 equal
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b100); // R6 taken
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEE, 3'b100); // R6 not taken
    apply(32'h8000_0000, 32'h0000_0000, 3'b100); // R6 msb only
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011); // R8
    apply(32'hFFFF_FFFF, 32'h1234_5678, 3'b101); // R8
    apply(32'h0000_0000, 32'hFFFF_FFFF, 3'b000); // R1/R7 zero via AND
    // random mix, including near-equal pairs
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom;
      case ($urandom_range(0, 3))
        0: rb = ra;
        1: rb = ra ^ (32'h1 << $urandom_range(0, 31));
        2: rb = -ra;
        default: rb = $urandom;
      endcase
      apply(ra, rb, 3'($urandom_range(0, 7)));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule